// File: doc/BRIEF.md
# Per-Slot Status Return Serializer

This block builds the serial status stream that travels back alongside an incoming framed data stream. The receiver's bit counter supplies the bit position within the current frame and a strobe for each bit. For every strobe the block emits one output bit on the same slot grid. The frame holds eight channel slots followed by a 24-bit sync region. Each slot returns the status of its own channel. Slot 0 carries channel 0, and each later slot carries the next channel up to slot 7.

Two frame geometries are selectable. In the long geometry a frame is 192 bits: eight 21-bit slots followed by the sync region. In the short geometry a frame is 128 bits: eight 13-bit slots followed by the sync region. In either geometry the first bit of every slot is zero. The remaining bits of the slot repeat the channel's status. All sync-region bits are zero, and so are any positions past the end of the frame.

The output side is a valid-only stream with no ready signal. `ret_valid` marks each produced bit, and the consumer must take the bit in that cycle because the block never stalls. Each strobe yields one bit one clock later. Gaps between strobes produce no output.

Top module: `sret_frame_tx`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first strobe, `ret_valid` and `ret_bit` are 0.
- R2: `ret_valid` is 1 in exactly the cycle after each cycle with `bit_en` high, and 0 otherwise. `ret_bit` is 0 whenever `ret_valid` is 0.
- R3: With `long_mode`=1, a strobe at position p with 21*n+1 <= p <= 21*n+20 (n in 0..7) yields the status bit of channel n, in bit n of `chan_status`.
- R4: With `long_mode`=0, a strobe at position p with 13*n+1 <= p <= 13*n+12 (n in 0..7) yields the status bit of channel n, in bit n of `chan_status`.
- R5: A strobe at the first position of any slot (21*n in long mode, 13*n in short mode) yields 0.
- R6: A strobe at any position beyond the eighth slot yields 0. This covers the sync region (168..191 long, 104..127 short) and any higher value.
- R7: Channel status is sampled only at the first bit of its slot. Changes on `chan_status` later in that slot do not alter the bits returned for the slot.
- R8: A strobe with `frame_lock`=0 yields 0. The remaining bits of any slot whose first bit was strobed without lock also yield 0, even once lock returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One-cycle strobe per frame bit from the receiver's counter |
| frame_lock | input | 1 | Receiver reports frame alignment |
| long_mode | input | 1 | 1 = 21-bit slots (192-bit frame), 0 = 13-bit slots (128-bit frame) |
| bit_pos | input | 8 | Position of the strobed bit within the frame |
| chan_status | input | 8 | Per-channel status, bit n for channel n |
| ret_bit | output | 1 | Serial status return bit |
| ret_valid | output | 1 | Qualifies `ret_bit`, one cycle after each strobe |

## Verification
The bench uses the default parameters: eight channels, slot lengths of 21 and 13, and a 24-bit sync region. With these values both frame geometries can be walked bit by bit in a few hundred cycles each. The walks cover every slot boundary, every sync bit, and positions beyond the short frame's end. Several status patterns run in both geometries, so a slot-to-channel swap or an off-by-one at a slot boundary shows up as a wrong bit. Directed cases then change the status mid-slot, drop lock at and inside a slot, and leave gaps between strobes.

// File: rtl/sret_pkg.sv
`timescale 1ns/1ps
package sret_pkg;
  typedef enum logic {
    GEO_SHORT = 1'b0,
    GEO_LONG  = 1'b1
  } frame_geo_e;
endpackage

// File: rtl/sret_slot_decode.sv
`timescale 1ns/1ps
module sret_slot_decode #(
  parameter int unsigned NUM_CH    = 8,
  parameter int unsigned LONG_LEN  = 21,
  parameter int unsigned SHORT_LEN = 13,
  parameter int unsigned POS_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sret_pkg::frame_geo_e geo,
  input  logic [POS_W-1:0]  pos,
  output logic [NUM_CH-1:0] slot_hot,
  output logic              slot_first,
  output logic              in_sync
);
  logic [31:0]       pos_w;
  logic [NUM_CH-1:0] first_hot;

  assign pos_w = 32'(pos);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
    localparam int unsigned LSTART = g * LONG_LEN;
    localparam int unsigned SSTART = g * SHORT_LEN;
    logic in_long, in_short;
    assign in_long  = (pos_w >= LSTART) && (pos_w < LSTART + LONG_LEN);
    assign in_short = (pos_w >= SSTART) && (pos_w < SSTART + SHORT_LEN);
    assign slot_hot[g]  = (geo == sret_pkg::GEO_LONG) ? in_long : in_short;
    assign first_hot[g] = (geo == sret_pkg::GEO_LONG) ? (pos_w == LSTART)
                                                      : (pos_w == SSTART);
  end

  assign slot_first = |first_hot;
  assign in_sync    = ~|slot_hot;

  // R3/R4: slots never overlap, so at most one slot claims a position
  p_one_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_hot));
  // R5: a slot start is always inside the slot it starts
  p_first_in_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    slot_first |-> (|slot_hot));
endmodule

// File: rtl/sret_status_hold.sv
`timescale 1ns/1ps
module sret_status_hold #(
  parameter int unsigned NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic              drop,
  input  logic [NUM_CH-1:0] slot_hot,
  input  logic [NUM_CH-1:0] status,
  output logic              held_bit,
  output logic              held_ok
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_bit <= 1'b0;
      held_ok  <= 1'b0;
    end else if (capture) begin
      held_bit <= |(slot_hot & status);
      held_ok  <= 1'b1;
    end else if (drop) begin
      held_ok  <= 1'b0;
    end
  end

  // R7: the held status only moves at a slot's first bit
  p_hold_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(held_bit));
  // R8: a lost lock invalidates the held value until the next capture
  p_drop_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (drop && !capture) |=> !held_ok);
endmodule

// File: rtl/sret_frame_tx.sv
`timescale 1ns/1ps
module sret_frame_tx #(
  parameter int unsigned NUM_CH    = 8,
  parameter int unsigned LONG_LEN  = 21,
  parameter int unsigned SHORT_LEN = 13,
  parameter int unsigned SYNC_LEN  = 24,
  localparam int unsigned FRAME_MAX = NUM_CH * LONG_LEN + SYNC_LEN,
  localparam int unsigned POS_W     = $clog2(FRAME_MAX)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              frame_lock,
  input  logic              long_mode,
  input  logic [POS_W-1:0]  bit_pos,
  input  logic [NUM_CH-1:0] chan_status,
  output logic              ret_bit,
  output logic              ret_valid
);
  import sret_pkg::*;

  frame_geo_e        geo;
  logic [NUM_CH-1:0] slot_hot;
  logic              slot_first, in_sync;
  logic              held_bit, held_ok;
  logic              capture, drop, nxt_bit;

  assign geo = frame_geo_e'(long_mode);

  sret_slot_decode #(
    .NUM_CH(NUM_CH), .LONG_LEN(LONG_LEN), .SHORT_LEN(SHORT_LEN), .POS_W(POS_W)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .geo(geo), .pos(bit_pos),
    .slot_hot(slot_hot), .slot_first(slot_first), .in_sync(in_sync)
  );

  assign capture = bit_en && frame_lock && slot_first;
  assign drop    = bit_en && !frame_lock;

  sret_status_hold #(.NUM_CH(NUM_CH)) u_hold (
    .clk(clk), .rst_n(rst_n), .capture(capture), .drop(drop),
    .slot_hot(slot_hot), .status(chan_status),
    .held_bit(held_bit), .held_ok(held_ok)
  );

  assign nxt_bit = frame_lock && !in_sync && !slot_first && held_ok && held_bit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ret_bit   <= 1'b0;
      ret_valid <= 1'b0;
    end else begin
      ret_valid <= bit_en;
      ret_bit   <= bit_en && nxt_bit;
    end
  end

  p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en |=> ret_valid);
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> (!ret_valid && !ret_bit));
  p_slot_start_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && slot_first) |=> !ret_bit);
  p_sync_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && in_sync) |=> !ret_bit);
  p_unlocked_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !frame_lock) |=> !ret_bit);
endmodule

// File: tb/sim_sret_frame_tx.sv
`timescale 1ns/1ps
module sim_sret_frame_tx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_en = 1'b0;
  logic       frame_lock = 1'b0;
  logic       long_mode = 1'b0;
  logic [7:0] bit_pos = '0;
  logic [7:0] chan_status = '0;
  logic       ret_bit, ret_valid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sret_frame_tx u0 (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .frame_lock(frame_lock),
    .long_mode(long_mode), .bit_pos(bit_pos), .chan_status(chan_status),
    .ret_bit(ret_bit), .ret_valid(ret_valid)
  );

  // {long_mode, status pattern}
  localparam logic [8:0] VEC [8] = '{
    {1'b1, 8'hA5}, {1'b0, 8'hA5}, {1'b1, 8'h5A}, {1'b0, 8'h3C},
    {1'b1, 8'h81}, {1'b0, 8'h7E}, {1'b1, 8'hFF}, {1'b0, 8'h01}
  };

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // drive one strobe, then check result one clock later
  task automatic strobe(input int pos, input logic [7:0] st, input logic lk,
                        input logic exp, input string req);
    bit_en = 1'b1; bit_pos = 8'(pos); chan_status = st; frame_lock = lk;
    @(negedge clk);
    bit_en = 1'b0;
    chk("R2 valid", ret_valid, 1'b1);
    chk(req, ret_bit, exp);
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R1 valid in reset", ret_valid, 1'b0);
    chk("R1 bit in reset", ret_bit, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid after reset", ret_valid, 1'b0);
    chk("R1 bit after reset", ret_bit, 1'b0);

    foreach (VEC[v]) begin
      logic lm; logic [7:0] pat; int len; int flen;
      lm = VEC[v][8]; pat = VEC[v][7:0];
      long_mode = lm;
      len  = lm ? 21 : 13;
      flen = 8 * len + 24;
      for (int p = 0; p < flen; p++) begin
        if (p >= 8 * len)        strobe(p, pat, 1'b1, 1'b0, "R6 sync");
        else if (p % len == 0)   strobe(p, pat, 1'b1, 1'b0, "R5 slot start");
        else if (lm)             strobe(p, pat, 1'b1, pat[p / len], "R3 long slot");
        else                     strobe(p, pat, 1'b1, pat[p / len], "R4 short slot");
      end
    end

    // R2: gap between strobes
    @(negedge clk);
    chk("R2 gap valid", ret_valid, 1'b0);
    chk("R2 gap bit", ret_bit, 1'b0);

    // R6: position past short frame end
    long_mode = 1'b0;
    strobe(150, 8'hFF, 1'b1, 1'b0, "R6 beyond frame");

    // R7: status changes after slot start are ignored (long)
    long_mode = 1'b1;
    strobe(21, 8'h02, 1'b1, 1'b0, "R5 slot1 start");
    for (int p = 22; p <= 41; p++) strobe(p, 8'h00, 1'b1, 1'b1, "R7 held one");
    strobe(42, 8'h00, 1'b1, 1'b0, "R5 slot2 start");
    for (int p = 43; p <= 45; p++) strobe(p, 8'hFF, 1'b1, 1'b0, "R7 held zero");

    // R8: lock absent at slot start blocks whole slot
    strobe(63, 8'hFF, 1'b0, 1'b0, "R8 unlocked start");
    for (int p = 64; p <= 70; p++) strobe(p, 8'hFF, 1'b1, 1'b0, "R8 stale slot");
    // R8: lock lost mid-slot
    strobe(84, 8'hFF, 1'b1, 1'b0, "R5 slot4 start");
    strobe(85, 8'hFF, 1'b1, 1'b1, "R3 slot4 bit");
    strobe(86, 8'hFF, 1'b0, 1'b0, "R8 unlocked mid");
    strobe(87, 8'hFF, 1'b1, 1'b0, "R8 after relock");
    strobe(105, 8'hFF, 1'b1, 1'b0, "R5 slot5 start");
    strobe(106, 8'hFF, 1'b1, 1'b1, "R8 recovered R3");

    // R1: reset mid-stream
    bit_en = 1'b1; bit_pos = 8'd107; rst_n = 1'b0;
    @(negedge clk);
    bit_en = 1'b0;
    chk("R1 reset mid-stream valid", ret_valid, 1'b0);
    chk("R1 reset mid-stream bit", ret_bit, 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule